// File: doc/BRIEF.md
# Processor Reset Sequencer With Vector Fetch

This block sits between the chip's master reset and a processor core. While master reset is high it keeps the core stopped, issues no memory traffic, and presents the initial control state. That state is a status-register image with tracing off, supervisor privilege on and the interrupt mask at its highest level, plus a vector base of zero.

Once reset drops, the block spends one cycle capturing the breakpoint input as a debug request. It then reads two 32-bit words from the vector table through a simple request/acknowledge read port. The word at the table base goes into the interrupt stack pointer, and the word four bytes above it goes into the program counter. After the second word is stored, the block raises a one-cycle start strobe and holds the core's run enable high from then on.

If master reset rises again at any point, the block drops back to the hold state at once. All initial values are applied again in that case.

Top module: `cpu_reset_seq`

## Requirements
- R1: While mst_rst is 1, mem_req, start and core_run are all 0 (any execution is aborted and nothing is fetched).
- R2: The status image reads sr_trace = 2'b00 (both trace bits clear), sr_super = 1 and sr_ipm = 3'd7, during reset and throughout the boot sequence.
- R3: vbr reads 0 during and after reset.
- R4: dbg_req takes the value of bkpt_in present in the cycle after the first clock edge following reset release. Later changes of bkpt_in are ignored, and dbg_req is 0 during reset.
- R5: The first read after release uses mem_addr = 0. Its mem_rdata is loaded into isp.
- R6: The second read uses mem_addr = 4. Its mem_rdata is loaded into pc.
- R7: A read holds mem_req high with a stable mem_addr until mem_ack is sampled high, for any number of wait cycles and with no timeout.
- R8: start pulses high for exactly one cycle, in the cycle after the second read is acknowledged, and never before both words are loaded. core_run is 1 from that cycle onward.
- R9: Raising mst_rst during the vector fetch immediately drops mem_req and core_run and clears isp, pc and dbg_req. The next release repeats the full sequence.
- R10: mem_ack pulses while no read is requested change neither isp nor pc and cause no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mst_rst | input | 1 | Master reset, active high, asynchronous assert |
| bkpt_in | input | 1 | Breakpoint request input sampled after release |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | ADDR_W | Byte address of the vector read |
| mem_ack | input | 1 | Read acknowledge, data valid with it |
| mem_rdata | input | DATA_W | Read data |
| sr_trace | output | 2 | Trace enable bits of the status image (T1,T0) |
| sr_super | output | 1 | Supervisor bit of the status image |
| sr_ipm | output | 3 | Interrupt priority mask of the status image |
| vbr | output | ADDR_W | Vector base value |
| isp | output | DATA_W | Loaded interrupt stack pointer |
| pc | output | DATA_W | Loaded program counter |
| dbg_req | output | 1 | Latched breakpoint sample |
| start | output | 1 | One-cycle strobe: begin instruction fetch at pc |
| core_run | output | 1 | Core may execute |

## Verification
The assertions assume that the memory side raises mem_ack only while mem_req is high, or else only outside the fetch states, and that mst_rst is high from time zero. The bench's responder follows both assumptions: it acknowledges each read after a programmed number of wait cycles, and it sends spurious acknowledges only once the core is running. The bench drives bkpt_in and mst_rst on falling edges only, so the sampling cycle and the asynchronous reassertion are clean. The bench then flips bkpt_in after the sampling cycle to show that later changes are ignored.

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int IPM_W  = 3
) (
  input  logic              clk,
  input  logic              mst_rst,
  input  logic              bkpt_in,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        sr_trace,
  output logic              sr_super,
  output logic [IPM_W-1:0]  sr_ipm,
  output logic [ADDR_W-1:0] vbr,
  output logic [DATA_W-1:0] isp,
  output logic [DATA_W-1:0] pc,
  output logic              dbg_req,
  output logic              start,
  output logic              core_run
);

  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(DATA_W / 8);

  typedef enum logic [2:0] {
    RESET_HOLD, SAMPLE_BKPT, FETCH_SP, FETCH_PC, RUN
  } st_t;

  st_t st;

  assign sr_trace = 2'b00;
  assign sr_super = 1'b1;
  assign sr_ipm   = {IPM_W{1'b1}};
  assign vbr      = '0;

  assign mem_req  = (st == FETCH_SP) || (st == FETCH_PC);
  assign mem_addr = (st == FETCH_PC) ? vbr + WORD_BYTES : vbr;
  assign core_run = (st == RUN);

  always_ff @(posedge clk or posedge mst_rst) begin
    if (mst_rst) begin
      st      <= RESET_HOLD;
      isp     <= '0;
      pc      <= '0;
      dbg_req <= 1'b0;
      start   <= 1'b0;
    end else begin
      start <= 1'b0;
      case (st)
        RESET_HOLD:  st <= SAMPLE_BKPT;
        SAMPLE_BKPT: begin
          dbg_req <= bkpt_in;
          st      <= FETCH_SP;
        end
        FETCH_SP: if (mem_ack) begin
          isp <= mem_rdata;
          st  <= FETCH_PC;
        end
        FETCH_PC: if (mem_ack) begin
          pc    <= mem_rdata;
          start <= 1'b1;
          st    <= RUN;
        end
        default: st <= RUN;
      endcase
    end
  end

endmodule

// File: rtl/cpu_reset_seq_chk.sv
module cpu_reset_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int IPM_W  = 3
) (
  input logic              clk,
  input logic              mst_rst,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [1:0]        sr_trace,
  input logic              sr_super,
  input logic [IPM_W-1:0]  sr_ipm,
  input logic [DATA_W-1:0] isp,
  input logic [DATA_W-1:0] pc,
  input logic              dbg_req,
  input logic              start,
  input logic              core_run
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    mst_rst |=> (!mem_req && !start && !core_run)); // R1

  AST_SR_INIT: assert property (@(posedge clk) disable iff (mst_rst)
    !core_run |-> (sr_trace == 2'b00 && sr_super && sr_ipm == {IPM_W{1'b1}})); // R2

  AST_BKPT_HOLD: assert property (@(posedge clk) disable iff (mst_rst)
    (mem_req || core_run) |=> $stable(dbg_req)); // R4

  AST_SP_LOAD: assert property (@(posedge clk) disable iff (mst_rst)
    (mem_req && mem_ack && mem_addr == '0) |=> (isp == $past(mem_rdata))); // R5

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (mst_rst)
    (mem_req && mem_ack && mem_addr == ADDR_W'(4)) |=> (pc == $past(mem_rdata))); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (mst_rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R7

  AST_START_PULSE: assert property (@(posedge clk) disable iff (mst_rst)
    start |=> !start); // R8

  AST_START_AFTER_PC: assert property (@(posedge clk) disable iff (mst_rst)
    $rose(start) |-> $past(mem_req && mem_ack && mem_addr == ADDR_W'(4))); // R8

  AST_RUN_QUIET: assert property (@(posedge clk) disable iff (mst_rst)
    core_run |=> (core_run && !mem_req && $stable(pc) && $stable(isp))); // R10

endmodule

bind cpu_reset_seq cpu_reset_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IPM_W(IPM_W)) u_chk (
  .clk(clk), .mst_rst(mst_rst), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .mem_rdata(mem_rdata), .sr_trace(sr_trace),
  .sr_super(sr_super), .sr_ipm(sr_ipm), .isp(isp), .pc(pc),
  .dbg_req(dbg_req), .start(start), .core_run(core_run)
);

// File: tb/cpu_reset_seq_tb.sv
`timescale 1ns/1ps
module cpu_reset_seq_tb;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int NV = 4;

  localparam logic        V_BK [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] V_SP [NV] = '{32'h0000_1000, 32'hFFFF_FFFC, 32'h1234_5678, 32'hA5A5_A5A4};
  localparam logic [31:0] V_PC [NV] = '{32'h0000_0400, 32'h8000_0000, 32'h9ABC_DEF0, 32'h0000_0008};
  localparam int          V_WS [NV] = '{0, 3, 0, 2};
  localparam int          V_WP [NV] = '{0, 0, 5, 2};

  logic clk = 0;
  logic mst_rst = 1;
  logic bkpt_in = 0;
  logic mem_ack = 0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic mem_req, dbg_req, start, core_run, sr_super;
  logic [ADDR_W-1:0] mem_addr, vbr;
  logic [1:0] sr_trace;
  logic [2:0] sr_ipm;
  logic [DATA_W-1:0] isp, pc;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cpu_reset_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .mst_rst(mst_rst), .bkpt_in(bkpt_in), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .sr_trace(sr_trace), .sr_super(sr_super), .sr_ipm(sr_ipm), .vbr(vbr),
    .isp(isp), .pc(pc), .dbg_req(dbg_req), .start(start), .core_run(core_run)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reset_state(input string tag);
    chk(!mem_req && !start && !core_run, {"R1 ", tag}, {29'd0, mem_req, start, core_run}, 32'd0);
    chk(sr_trace == 2'b00 && sr_super && sr_ipm == 3'd7, {"R2 ", tag},
        {26'd0, sr_trace, sr_super, sr_ipm}, {26'd0, 2'b00, 1'b1, 3'd7});
    chk(vbr == '0, {"R3 ", tag}, {8'd0, vbr}, 32'd0);
    chk(!dbg_req && isp == '0 && pc == '0, {"R9 ", tag}, isp | pc | {31'd0, dbg_req}, 32'd0);
  endtask

  task automatic boot(input logic bk, input logic [31:0] sp, input logic [31:0] pcw,
                      input int wsp, input int wpc, input string tag);
    int nreq = 0;
    int cnt = 0;
    bit seen = 0;
    mst_rst = 1;
    repeat (3) @(negedge clk);
    chk_reset_state(tag);
    mst_rst = 0;
    bkpt_in = bk;
    for (int i = 1; i < 200 && !seen; i++) begin
      @(negedge clk);
      mem_ack = 0;
      if (i == 2) bkpt_in = ~bk;
      if (start) seen = 1;
      else if (mem_req) begin
        chk(sr_trace == 2'b00 && sr_super && sr_ipm == 3'd7, {"R2 fetch ", tag},
            {29'd0, sr_ipm}, 32'd7);
        if (cnt == ((nreq == 0) ? wsp : wpc)) begin
          if (nreq == 0) chk(mem_addr == 24'd0, {"R5 addr ", tag}, {8'd0, mem_addr}, 32'd0);
          else chk(mem_addr == 24'd4, {"R6 addr ", tag}, {8'd0, mem_addr}, 32'd4);
          mem_ack = 1;
          mem_rdata = (nreq == 0) ? sp : pcw;
          nreq++;
          cnt = 0;
        end else begin
          if (cnt > 0) chk(mem_addr == ((nreq == 0) ? 24'd0 : 24'd4), {"R7 wait ", tag},
                           {8'd0, mem_addr}, (nreq == 0) ? 32'd0 : 32'd4);
          cnt++;
        end
      end
    end
    chk(seen && nreq == 2, {"R8 start after two reads ", tag}, nreq, 32'd2);
    chk(isp == sp, {"R5 isp ", tag}, isp, sp);
    chk(pc == pcw, {"R6 pc ", tag}, pc, pcw);
    chk(dbg_req == bk, {"R4 bkpt ", tag}, {31'd0, dbg_req}, {31'd0, bk});
    chk(core_run && !mem_req, {"R8 run ", tag}, {30'd0, core_run, mem_req}, 32'd2);
    @(negedge clk);
    chk(!start && core_run, {"R8 pulse width ", tag}, {30'd0, start, core_run}, 32'd1);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_reset_state("initial");

    for (int v = 0; v < NV; v++)
      boot(V_BK[v], V_SP[v], V_PC[v], V_WS[v], V_WP[v], $sformatf("vec%0d", v));

    // R10: acknowledges with no request pending
    mem_ack = 1;
    mem_rdata = 32'hDEAD_BEEF;
    repeat (3) begin
      @(negedge clk);
      chk(!start, "R10 no start", {31'd0, start}, 32'd0);
    end
    mem_ack = 0;
    chk(pc == V_PC[NV-1] && isp == V_SP[NV-1], "R10 pc/isp kept", pc, V_PC[NV-1]);

    // R9: reassert during the second read
    mst_rst = 1;
    @(negedge clk);
    mst_rst = 0;
    bkpt_in = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req && mem_addr == 24'd0) begin
        mem_ack = 1;
        mem_rdata = 32'h5555_0000;
      end else if (mem_req && mem_addr == 24'd4) break;
    end
    chk(isp == 32'h5555_0000 && mem_req, "R9 mid fetch", isp, 32'h5555_0000);
    mst_rst = 1;
    #1;
    chk(!mem_req && !core_run, "R9 req dropped", {30'd0, mem_req, core_run}, 32'd0);
    chk(isp == '0 && pc == '0 && !dbg_req, "R9 cleared", isp, 32'd0);
    boot(1'b0, 32'h0000_2000, 32'h0000_0100, 1, 1, "after R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule